// File: doc/BRIEF.md
# Multi-Stage Lead-Acid Charge Sequencer

The block steps a lead-acid battery through a four-stage charge program. It starts with constant-current bulk charging. Next comes a constant-voltage hold at the bulk level, then a hold at the float level. Last is an extended hold at a reduced level close to open-circuit voltage. After that it alternates between reduced-float and float for as long as no new cycle is requested.

Three digital flags come from external comparators. Each reports whether the battery sits at or above one voltage reference: the bulk, float or reduced-float reference. A start request begins a fresh cycle. The block drives one charge-enable line for the charging transistor and a one-hot stage indication.

In bulk the enable stays on. In every constant-voltage stage the enable is on only while that stage's own flag is low, so the battery is charged in pulses. Leaving bulk depends on voltage alone. All later changes of stage are timed in minute ticks from an internal prescaler. A test setting shortens the tick to one second and sets every stage length to sixty ticks.

Top module: `charge_sequencer`

## Requirements
- R1: After reset the block is idle. `stage_o` is 0 and `chg_en_o` is 0, and all three comparator flags are ignored until a start request arrives.
- R2: A rising edge on `start_i` forces the bulk stage from any state. The new stage appears three clock edges after the input changes. A start held high does not trigger again.
- R3: Bulk is left only for absorption, and only when `at_bulk_i` is high. Absorption shows three edges after the flag rises. Without that flag, bulk holds indefinitely.
- R4: Absorption lasts exactly ABS_MIN*60*CLK_HZ clock cycles and is then followed by float. Every timed stage starts its count afresh when it is entered.
- R5: Float lasts exactly FLT_MIN*60*CLK_HZ cycles and is then followed by reduced-float.
- R6: Reduced-float lasts exactly RED_MIN*60*CLK_HZ cycles and then returns to float. The float and reduced-float pair repeats until the next start.
- R7: In bulk `chg_en_o` is 1 on every cycle, whatever the flags are.
- R8: In absorption, float and reduced-float, `chg_en_o` is the inverse of `at_bulk_i`, `at_float_i` and `at_reduced_i` respectively. It follows its flag two edges after the flag changes. The other two flags have no effect.
- R9: `stage_o` is one-hot or zero. Bit 0 is bulk, bit 1 absorption, bit 2 float and bit 3 reduced-float.
- R10: With FAST_TEST=1 the tick period is CLK_HZ cycles and every timed stage lasts 60 ticks, that is 60*CLK_HZ cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request for a new charge cycle, acts on its rising edge |
| at_bulk_i | input | 1 | Battery at or above the bulk reference |
| at_float_i | input | 1 | Battery at or above the float reference |
| at_reduced_i | input | 1 | Battery at or above the reduced-float reference |
| stage_o | output | 4 | One-hot stage: bulk, absorb, float, reduced |
| chg_en_o | output | 1 | Charging transistor enable |

## Verification
The bench measures each timed stage to the exact cycle, one cycle before and on the cycle of the change. A timer that failed to restart on entry, or that was off by one, would therefore move the stage early or late. It holds start high through later stages and sweeps the flags that do not belong to the current stage. A level-sensitive start would pin the controller in bulk, and a wrong flag-to-stage pairing would make the pulsed enable follow the wrong comparator. It also runs the reduced-float and float loop twice and repeats the timing in the one-second test setting. A missing return edge or a wrong divide ratio in either mode would show up there.

// File: rtl/charge_sequencer.sv
module charge_sequencer #(
  parameter int CLK_HZ    = 25000,
  parameter bit FAST_TEST = 1'b0,
  parameter int ABS_MIN   = 120,
  parameter int FLT_MIN   = 60,
  parameter int RED_MIN   = 4320
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       at_bulk_i,
  input  logic       at_float_i,
  input  logic       at_reduced_i,
  output logic [3:0] stage_o,
  output logic       chg_en_o
);

  localparam int DIV   = FAST_TEST ? CLK_HZ : 60 * CLK_HZ;
  localparam int D_ABS = FAST_TEST ? 60 : ABS_MIN;
  localparam int D_FLT = FAST_TEST ? 60 : FLT_MIN;
  localparam int D_RED = FAST_TEST ? 60 : RED_MIN;
  localparam int D_MAX = (D_ABS > D_FLT) ? ((D_ABS > D_RED) ? D_ABS : D_RED)
                                         : ((D_FLT > D_RED) ? D_FLT : D_RED);
  localparam int DW = $clog2(DIV + 1);
  localparam int TW = $clog2(D_MAX + 1);

  typedef enum logic [2:0] {IDLE, BULK, ABSB, FLT, RED} st_t;

  st_t st, nxt;
  logic [2:0] flg_s1, flg_s2;
  logic [2:0] go_sh;
  logic [DW-1:0] div_q;
  logic [TW-1:0] tmr_q, cur_dur;
  logic go, tick, timed, expire, chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_s1 <= '0;
      flg_s2 <= '0;
      go_sh  <= '0;
    end else begin
      flg_s1 <= {at_reduced_i, at_float_i, at_bulk_i};
      flg_s2 <= flg_s1;
      go_sh  <= {go_sh[1:0], start_i};
    end
  end

  assign go    = go_sh[1] & ~go_sh[2];
  assign tick  = (div_q == DW'(DIV - 1));
  assign timed = (st == ABSB) || (st == FLT) || (st == RED);

  always_comb begin
    case (st)
      ABSB:    cur_dur = TW'(D_ABS);
      FLT:     cur_dur = TW'(D_FLT);
      RED:     cur_dur = TW'(D_RED);
      default: cur_dur = '1;
    endcase
  end

  assign expire = timed && tick && (tmr_q == cur_dur - 1'b1);

  always_comb begin
    nxt = st;
    if (go) nxt = BULK;
    else begin
      case (st)
        BULK:    if (flg_s2[0]) nxt = ABSB;
        ABSB:    if (expire) nxt = FLT;
        FLT:     if (expire) nxt = RED;
        RED:     if (expire) nxt = FLT;
        default: nxt = st;
      endcase
    end
  end

  assign chg = (nxt != st);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= IDLE;
      div_q <= '0;
      tmr_q <= '0;
    end else begin
      st <= nxt;
      if (chg || tick) div_q <= '0;
      else             div_q <= div_q + 1'b1;
      if (chg)                tmr_q <= '0;
      else if (tick && timed) tmr_q <= tmr_q + 1'b1;
    end
  end

  assign stage_o  = {st == RED, st == FLT, st == ABSB, st == BULK};
  assign chg_en_o = (st == BULK)
                  | ((st == ABSB) & ~flg_s2[0])
                  | ((st == FLT)  & ~flg_s2[1])
                  | ((st == RED)  & ~flg_s2[2]);

  // R9
  stage_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_o));

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 4'b0000) |-> !chg_en_o);

  // R2
  start_bulk_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> stage_o[0]);

  // R3
  absorb_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stage_o[1]) |-> $past(stage_o[0]) && $past(flg_s2[0]));

  // R6
  reduced_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stage_o[3]) |-> $past(stage_o[2]));

  // R7
  bulk_enable_chk: assert property (@(posedge clk) disable iff (rst)
    stage_o[0] |-> chg_en_o);

  // R4
  timer_range_chk: assert property (@(posedge clk) disable iff (rst)
    timed |-> (tmr_q < cur_dur));

endmodule

// File: tb/charge_sequencer_tb_top.sv
module charge_sequencer_tb_top;

  localparam int A_HZ = 1, A_ABS = 3, A_FLT = 2, A_RED = 4;
  localparam int A_DIV = 60 * A_HZ;
  localparam int B_HZ = 3;
  localparam int B_LEN = 60 * B_HZ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_a = 0, fb_a = 0, ff_a = 0, fr_a = 0;
  logic st_b = 0, fb_b = 0, ff_b = 0, fr_b = 0;
  logic [3:0] stg_a, stg_b;
  logic en_a, en_b;
  int checks = 0, errors = 0, age = 0;
  bit done = 0;

  always #5 clk = ~clk;

  charge_sequencer #(.CLK_HZ(A_HZ), .FAST_TEST(1'b0), .ABS_MIN(A_ABS),
                     .FLT_MIN(A_FLT), .RED_MIN(A_RED)) dut_i (
    .clk(clk), .rst(rst), .start_i(st_a), .at_bulk_i(fb_a),
    .at_float_i(ff_a), .at_reduced_i(fr_a), .stage_o(stg_a), .chg_en_o(en_a));

  charge_sequencer #(.CLK_HZ(B_HZ), .FAST_TEST(1'b1), .ABS_MIN(500),
                     .FLT_MIN(500), .RED_MIN(500)) dut_fast_i (
    .clk(clk), .rst(rst), .start_i(st_b), .at_bulk_i(fb_b),
    .at_float_i(ff_b), .at_reduced_i(fr_b), .stage_o(stg_b), .chg_en_o(en_b));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
    age += n;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    check("R1 idle stage", stg_a, 0);
    check("R1 idle enable", en_a, 0);
    fb_a = 1; fr_a = 1;
    step(6);
    check("R1 flags ignored stage", stg_a, 0);
    check("R1 flags ignored enable", en_a, 0);
    fb_a = 0; fr_a = 0;
    step(4);

    st_a = 1;
    step(2);
    check("R2 start latency", stg_a, 0);
    step(1);
    check("R2 start to bulk", stg_a, 1);
    check("R7 bulk enable", en_a, 1);
    ff_a = 1; fr_a = 1;
    step(250);
    check("R3 bulk holds", stg_a, 1);
    check("R7 bulk enable with flags", en_a, 1);

    fb_a = 1;
    step(2);
    check("R3 flag latency", stg_a, 1);
    step(1);
    check("R3 bulk to absorb", stg_a, 2);
    age = 0;
    check("R8 absorb flag high", en_a, 0);
    fb_a = 0;
    step(1);
    check("R8 absorb latency", en_a, 0);
    step(1);
    check("R8 absorb flag low", en_a, 1);
    fb_a = 1;
    step(2);
    ff_a = 0; fr_a = 0;
    step(3);
    check("R8 absorb other flags ignored", en_a, 0);
    step(A_ABS * A_DIV - 1 - age);
    check("R4 absorb end minus one", stg_a, 2);
    check("R2 held start no retrigger", stg_a, 2);
    step(1);
    check("R4 absorb to float", stg_a, 4);
    age = 0;
    check("R8 float flag low", en_a, 1);
    ff_a = 1; fb_a = 0;
    step(2);
    check("R8 float flag high", en_a, 0);
    step(A_FLT * A_DIV - 1 - age);
    check("R5 float end minus one", stg_a, 4);
    step(1);
    check("R5 float to reduced", stg_a, 8);
    age = 0;
    check("R8 reduced flag low", en_a, 1);
    fr_a = 1; ff_a = 0;
    step(2);
    check("R8 reduced flag high", en_a, 0);
    step(A_RED * A_DIV - 1 - age);
    check("R6 reduced end minus one", stg_a, 8);
    step(1);
    check("R6 reduced to float", stg_a, 4);
    check("R8 float follows own flag", en_a, 1);
    age = 0;
    step(A_FLT * A_DIV - 1);
    check("R6 loop float", stg_a, 4);
    step(1);
    check("R6 loop reduced", stg_a, 8);
    age = 0;
    step(A_RED * A_DIV - 1);
    check("R6 second reduced", stg_a, 8);
    step(1);
    check("R6 second float", stg_a, 4);

    step(5);
    st_a = 0;
    step(3);
    fb_a = 1;
    st_a = 1;
    step(2);
    check("R2 restart latency", stg_a, 4);
    step(1);
    check("R2 restart to bulk", stg_a, 1);
    check("R7 enable on restart", en_a, 1);
    step(1);
    check("R3 immediate absorb", stg_a, 2);
    check("R9 absorb code", stg_a, 4'b0010);

    st_b = 1;
    step(3);
    check("R10 fast start", stg_b, 1);
    fb_b = 1;
    step(3);
    check("R10 fast absorb", stg_b, 2);
    age = 0;
    step(B_LEN - 1);
    check("R10 fast absorb end minus one", stg_b, 2);
    step(1);
    check("R10 fast float", stg_b, 4);
    step(B_LEN - 1);
    check("R10 fast float end minus one", stg_b, 4);
    step(1);
    check("R10 fast reduced", stg_b, 8);
    step(B_LEN);
    check("R10 fast back to float", stg_b, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule